// File: doc/BRIEF.md
# Per-Pin Level and Edge Interrupt Controller

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Every pin produces four event flags: two that follow the present level of the pin (low, high) and two that record transitions (falling, rising). The pins are first brought into the clock domain by a two-stage synchroniser. A third register stage keeps the previous sample, and edges are found by comparing against it.

The level flags are not stored. They follow the synchronised pin and nothing can clear them. The edge flags stay set until software writes a one to them. Each processor has its own enable mask and its own masked status view, and it drives its own interrupt line. A separate wake mask drives a wake line that can restart a stopped oscillator. Registers sit on a simple word bus. Reads are combinational from the address, and writes take effect on the clock edge.

Top module: `pin_irq_ctrl`

## Requirements
- R1: Inside each pin's 4-bit group the event flags are ordered bit 0 level low, bit 1 level high, bit 2 falling edge, bit 3 rising edge.
- R2: Pin n occupies bits 4*(n mod 8) to 4*(n mod 8)+3 of word n/8. The address is {region[2:0], word[1:0]}. Region codes: 0 raw status, 1 processor-0 enable, 2 processor-0 masked status, 3 processor-1 enable, 4 processor-1 masked status, 5 wake enable, 6 wake masked status.
- R3: Level flags are live. Level high equals the synchronised pin and level low is its inverse. Writing ones to level-flag positions in region 0 changes nothing.
- R4: A pin change sampled at clock edge k shows in the level flags after edge k+1, and sets the matching edge flag at edge k+2. Edge flags then hold.
- R5: Writing a one to an edge-flag position in region 0 clears that flag. If a new edge sets the flag in the same cycle, the flag stays set.
- R6: Enable regions read back what was written. Each masked status region reads raw status AND that target's enable.
- R7: irq_o[p] is high exactly when some bit of processor p's masked status is set. The two processors are independent.
- R8: wake_o is high exactly when some bit of raw status AND the wake enable is set.
- R9: After reset all enables and edge flags are zero and irq_o and wake_o are low. Bits for pins that do not exist and unused regions read zero. Writes to masked status regions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| we_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | ADDR_W | Word address {region, word} |
| wdata_i | input | 32 | Write data; in region 0 a one clears edge flags |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | NUM_CPU | One interrupt line per processor |
| wake_o | output | 1 | Wake request from the wake mask |

## Verification
The bench counts the clock edges between a pin change and the level and edge flags. A design with one synchroniser stage too few or too many would fail that count. It writes ones over a pin's whole group while the level holds. A design that let level flags be cleared, or that cleared the level as well as the edge, would read back the wrong group. It lines up a clear with the cycle in which a new falling edge is latched. A clear-wins priority would lose that edge. Masks are set on one processor only, to show that the other line stays low. The bench also reads the padding pins of the last word, and writes to a status view to show that neither enable nor status changes.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int EV_PER_PIN    = 4;
  localparam int PINS_PER_WORD = 8;
  localparam int BUS_W         = 32;
  localparam int EV_LVL_LO     = 0;
  localparam int EV_LVL_HI     = 1;
  localparam int EV_EDGE_FALL  = 2;
  localparam int EV_EDGE_RISE  = 3;
endpackage

// File: rtl/pic_pin_sync.sv
module pic_pin_sync #(
  parameter int N = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pic_event_bank.sv
module pic_event_bank import pic_pkg::*; #(
  parameter int N = 30,
  localparam int EVW = N * EV_PER_PIN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   cur_i,
  input  logic [N-1:0]   prev_i,
  input  logic [2*N-1:0] clr_i,   // per pin {rise, fall}
  output logic [EVW-1:0] raw_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic fall_q, rise_q;
    logic fall_set, rise_set;

    assign fall_set = prev_i[p] & ~cur_i[p];
    assign rise_set = ~prev_i[p] & cur_i[p];

    // a new edge beats a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fall_q <= 1'b0;
        rise_q <= 1'b0;
      end else begin
        fall_q <= fall_set | (fall_q & ~clr_i[2*p]);
        rise_q <= rise_set | (rise_q & ~clr_i[2*p+1]);
      end
    end

    assign raw_o[p*EV_PER_PIN + EV_LVL_LO]    = ~cur_i[p];
    assign raw_o[p*EV_PER_PIN + EV_LVL_HI]    = cur_i[p];
    assign raw_o[p*EV_PER_PIN + EV_EDGE_FALL] = fall_q;
    assign raw_o[p*EV_PER_PIN + EV_EDGE_RISE] = rise_q;
  end
endmodule

// File: rtl/pic_mask_or.sv
module pic_mask_or #(
  parameter int W = 120
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] masked_o,
  output logic         hit_o
);
  assign masked_o = raw_i & en_i;
  assign hit_o    = |masked_o;
endmodule

// File: rtl/pic_regif.sv
module pic_regif import pic_pkg::*; #(
  parameter int N       = 30,
  parameter int T       = 3,
  parameter int RGN_W   = 3,
  parameter int WORD_AW = 2,
  localparam int ADDR_W = RGN_W + WORD_AW,
  localparam int NW     = (N + PINS_PER_WORD - 1) / PINS_PER_WORD,
  localparam int EVW    = N * EV_PER_PIN,
  localparam int PW     = NW * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [EVW-1:0]   raw_i,
  input  logic [T*EVW-1:0] masked_i,
  output logic [T*EVW-1:0] en_o,
  output logic [2*N-1:0]   clr_o,
  output logic [BUS_W-1:0] rdata_o
);
  logic [RGN_W-1:0]   rgn;
  logic [WORD_AW-1:0] word;
  logic [WORD_AW+4:0] sh;
  logic [EVW-1:0]     wbits, wsel;
  logic               raw_wr;
  logic [PW-1:0]      rd_src;

  assign rgn    = addr_i[ADDR_W-1 -: RGN_W];
  assign word   = addr_i[WORD_AW-1:0];
  assign sh     = {word, 5'd0};
  assign wbits  = EVW'(PW'(wdata_i) << sh);
  assign wsel   = EVW'(PW'({BUS_W{1'b1}}) << sh);
  assign raw_wr = we_i && (rgn == '0);

  for (genvar p = 0; p < N; p++) begin : g_clr
    assign clr_o[2*p]   = raw_wr & wbits[p*EV_PER_PIN + EV_EDGE_FALL];
    assign clr_o[2*p+1] = raw_wr & wbits[p*EV_PER_PIN + EV_EDGE_RISE];
  end

  for (genvar t = 0; t < T; t++) begin : g_en
    logic [EVW-1:0] en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        en_q <= '0;
      else if (we_i && (rgn == RGN_W'(2*t + 1)))
        en_q <= (en_q & ~wsel) | (wbits & wsel);
    end
    assign en_o[t*EVW +: EVW] = en_q;
  end

  always_comb begin
    rd_src = '0;
    if (rgn == '0) rd_src = PW'(raw_i);
    for (int t = 0; t < T; t++) begin
      if (rgn == RGN_W'(2*t + 1)) rd_src = PW'(en_o[t*EVW +: EVW]);
      if (rgn == RGN_W'(2*t + 2)) rd_src = PW'(masked_i[t*EVW +: EVW]);
    end
  end

  assign rdata_o = BUS_W'(rd_src >> sh);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl import pic_pkg::*; #(
  parameter int  NUM_PINS = 30,
  parameter int  NUM_CPU  = 2,
  localparam int NW       = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
  localparam int WORD_AW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int NUM_TGT  = NUM_CPU + 1,
  localparam int RGN_W    = $clog2(2*NUM_TGT + 1),
  localparam int ADDR_W   = RGN_W + WORD_AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_CPU-1:0]  irq_o,
  output logic                wake_o
);
  localparam int EVW = NUM_PINS * EV_PER_PIN;

  logic [NUM_PINS-1:0]    pin_cur, pin_prev;
  logic [2*NUM_PINS-1:0]  edge_clr;
  logic [EVW-1:0]         raw;
  logic [NUM_TGT*EVW-1:0] en_all, masked_all;
  logic [NUM_TGT-1:0]     hit;

  pic_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .cur_o (pin_cur),
    .prev_o(pin_prev)
  );

  pic_event_bank #(.N(NUM_PINS)) u_events (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (pin_cur),
    .prev_i(pin_prev),
    .clr_i (edge_clr),
    .raw_o (raw)
  );

  pic_regif #(
    .N      (NUM_PINS),
    .T      (NUM_TGT),
    .RGN_W  (RGN_W),
    .WORD_AW(WORD_AW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .raw_i   (raw),
    .masked_i(masked_all),
    .en_o    (en_all),
    .clr_o   (edge_clr),
    .rdata_o (rdata_o)
  );

  // targets 0..NUM_CPU-1 are processors, target NUM_CPU is wake
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    pic_mask_or #(.W(EVW)) u_mask (
      .raw_i   (raw),
      .en_i    (en_all[t*EVW +: EVW]),
      .masked_o(masked_all[t*EVW +: EVW]),
      .hit_o   (hit[t])
    );
  end

  assign irq_o  = hit[NUM_CPU-1:0];
  assign wake_o = hit[NUM_CPU];
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int N       = 30,
  parameter int NUM_CPU = 2,
  localparam int EVW    = N * 4,
  localparam int NT     = NUM_CPU + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [EVW-1:0]     raw_i,
  input logic [2*N-1:0]     clr_i,
  input logic [NT*EVW-1:0]  en_i,
  input logic [NUM_CPU-1:0] irq_i,
  input logic               wake_i
);
  logic [NT-1:0] hits;
  assign hits = {wake_i, irq_i};

  for (genvar i = 0; i < N; i++) begin : g_pin
    a_r3_level_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(raw_i[4*i +: 2]) == 1);
    a_r4_rise_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_i[4*i+3]) |-> ($past(raw_i[4*i+1]) && !$past(raw_i[4*i+1], 2)));
    a_r4_fall_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_i[4*i+2]) |-> ($past(raw_i[4*i]) && !$past(raw_i[4*i], 2)));
    a_r5_rise_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_i[4*i+3] && !clr_i[2*i+1]) |=> raw_i[4*i+3]);
    a_r5_fall_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_i[4*i+2] && !clr_i[2*i]) |=> raw_i[4*i+2]);
  end

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    a_r7_quiet_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[t*EVW +: EVW] == '0) |-> !hits[t]);
  end
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N(NUM_PINS), .NUM_CPU(NUM_CPU)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .raw_i (raw),
  .clr_i (edge_clr),
  .en_i  (en_all),
  .irq_i (irq_o),
  .wake_i(wake_o)
);

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;
  localparam int N  = 30;
  localparam int NC = 2;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire  [NC-1:0] irq;
  wire           wake;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pin_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // reference model built from the requirements
  logic [N-1:0] m1, m2, mp, mf, mr;
  logic [119:0] men [3];
  wire  [127:0] b_wide = 128'(wdata) << {addr[1:0], 5'd0};
  wire  [127:0] b_msk  = 128'(32'hFFFF_FFFF) << {addr[1:0], 5'd0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; mp <= '0; mf <= '0; mr <= '0;
      for (int t = 0; t < 3; t++) men[t] <= '0;
    end else begin
      m1 <= pins;
      m2 <= m1;
      mp <= m2;
      for (int i = 0; i < N; i++) begin
        mf[i] <= (!m2[i] && mp[i]) || (mf[i] && !(we && addr[4:2] == 3'd0 && b_wide[4*i+2]));
        mr[i] <= (m2[i] && !mp[i]) || (mr[i] && !(we && addr[4:2] == 3'd0 && b_wide[4*i+3]));
      end
      for (int t = 0; t < 3; t++)
        if (we && addr[4:2] == 3'(2*t+1))
          men[t] <= (men[t] & ~b_msk[119:0]) | (b_wide[119:0] & b_msk[119:0]);
    end
  end

  function automatic logic [119:0] m_raw();
    logic [119:0] r;
    for (int i = 0; i < N; i++) r[4*i +: 4] = {mr[i], mf[i], m2[i], ~m2[i]};
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [127:0] src;
    logic [119:0] r;
    r = m_raw();
    case (a[4:2])
      3'd0: src = 128'(r);
      3'd1: src = 128'(men[0]);
      3'd2: src = 128'(r & men[0]);
      3'd3: src = 128'(men[1]);
      3'd4: src = 128'(r & men[1]);
      3'd5: src = 128'(men[2]);
      3'd6: src = 128'(r & men[2]);
      default: src = '0;
    endcase
    return src[32*a[1:0] +: 32];
  endfunction

  function automatic logic [2:0] exp_hits();
    logic [119:0] r;
    logic [2:0] h;
    r = m_raw();
    for (int t = 0; t < 3; t++) h[t] = |(r & men[t]);
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic nib(input string tag, input logic [AW-1:0] a, input logic [3:0] exp);
    addr = a;
    #1;
    chk(tag, (rdata >> 4) & 32'hF, 32'(exp));
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (R1..R9 run): actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 irq after reset", 32'(irq), 32'h0);
    chk("R9 wake after reset", 32'(wake), 32'h0);
    rd("R9 enable cleared", 5'd4, 32'h0);
    rd("R1 R3 level-low flags at reset", 5'd0, 32'h1111_1111);
    rd("R2 R9 padding pins read zero", 5'd3, 32'h0011_1111);
    rd("R9 unused region", 5'd28, 32'h0);

    // latency of pin 9 (word 1, nibble 1)
    @(negedge clk);
    pins[9] = 1'b1;
    nib("R4 before any edge", 5'd1, 4'h1);
    @(negedge clk);
    nib("R4 one edge later", 5'd1, 4'h1);
    @(negedge clk);
    nib("R2 R4 level high after two edges", 5'd1, 4'h2);
    @(negedge clk);
    nib("R1 R4 rise latched after three edges", 5'd1, 4'hA);
    @(negedge clk);
    nib("R4 rise holds", 5'd1, 4'hA);

    // write ones to the whole group: level stays, rise clears
    wr(5'd1, 32'h0000_00F0);
    nib("R3 R5 level kept, edge cleared", 5'd1, 4'h2);

    // processor-0 enable only
    wr(5'd5, 32'h0000_0020);
    #1;
    chk("R7 irq0 only", 32'(irq), 32'h1);
    rd("R6 cpu0 masked view", 5'd9, 32'h0000_0020);
    rd("R6 cpu1 masked view", 5'd17, 32'h0);
    chk("R8 wake idle", 32'(wake), 32'h0);

    wr(5'd21, 32'h0000_0020);
    #1;
    chk("R8 wake raised", 32'(wake), 32'h1);
    rd("R8 wake masked view", 5'd25, 32'h0000_0020);

    wr(5'd9, 32'h0);
    rd("R9 status write ignored (enable)", 5'd5, 32'h0000_0020);
    rd("R9 status write ignored (view)", 5'd9, 32'h0000_0020);

    // falling edge latched in the same cycle as its clear
    @(negedge clk);
    pins[9] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 5'd1; wdata = 32'h0000_0040;
    @(negedge clk);
    we = 1'b0;
    nib("R5 set wins over clear", 5'd1, 4'h5);
    chk("R3 R7 level irq drops with pin", 32'(irq), 32'h0);
    wr(5'd1, 32'h0000_0040);
    nib("R5 clear removes fall", 5'd1, 4'h1);

    // mixed random traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        if ($urandom % 6 == 0) pins[i] = ~pins[i];
      addr  = AW'($urandom);
      we    = ($urandom % 3 == 0);
      wdata = (cyc % 2 == 1) ? ($urandom & $urandom & $urandom) : $urandom;
      #1;
      chk("R2 R6 R8 random read", rdata, exp_read(addr));
      chk("R7 random irq", 32'(irq), 32'(exp_hits() & 3'b011));
      chk("R8 random wake", 32'(wake), 32'(exp_hits() >> 2));
    end
    @(negedge clk);
    we = 1'b0;
    summary();
  end
endmodule